// File: doc/BRIEF.md
# Tree Network Route Node

This block is one switching node of an on-die tree network that links sixteen cache banks laid out as a 4x4 grid. Twelve edge banks each hang off one of four central banks: 5, 6, 9 and 10. The four central banks hang off a single root switch. A single parameter makes an instance a leaf node, a central node or the root. A leaf node has only a local port and an uplink. A central node has a local port, three child ports and an uplink. The root has four downlinks, one to each central bank.

Every flit is self-routing. Its top four bits name the destination bank, so a node finds the output port from those bits and its own bank number, with no lookup or search. Flits are stored in a per-input FIFO and move through a three-stage pipeline: buffer write, then route and arbitration, then output register. A flit leaves only when the output holds a credit for a free slot in the downstream buffer. When several inputs want the same output, a round-robin pointer for that output picks one. When a flit leaves an input buffer, a one-cycle credit pulse goes back upstream. The routing is symmetric, so a reply addressed to the requester travels back along the same links in reverse.

Top module: `tree_route_node`

## Requirements
- R1: A flit whose destination equals the node's own bank number (ID) leaves on port 0, the local port, and never on any other port. This holds for leaf and central nodes.
- R2: A leaf node sends every flit whose destination differs from its ID out on port 1, the uplink.
- R3: A central node sends a flit addressed to one of its three leaves to child ports 1 to 3. The leaves take these ports in ascending order of bank number. Central 5 owns leaves 0, 1 and 4; central 6 owns 2, 3 and 7; central 9 owns 8, 12 and 13; central 10 owns 11, 14 and 15.
- R4: A central node sends a flit for any bank outside its own group of four to port 4, the uplink.
- R5: The root sends a flit to port {dest[3], dest[1]}. Ports 0, 1, 2 and 3 connect to centrals 5, 6, 9 and 10.
- R6: A flit sampled on an input at clock edge k, with no contention, appears on its output port in the cycle after edge k+2 and not earlier.
- R7: Each output starts with DEPTH credits after reset. Each flit sent uses one credit. Each cycle that credit_in is high returns one. An output with no credits sends nothing, and the flits wait in their input buffers.
- R8: Inputs that contend for the same output are served round-robin. After reset the pointer is at input 0. After a grant to input i, the search next starts at input i+1.
- R9: in_credit[i] pulses for one cycle, in the cycle after the edge at which a flit leaves input buffer i.
- R10: Flits that enter through one input and go to one output leave in the order they arrived.
- R11: During reset, and in the cycle after reset is released, out_valid and in_credit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NP | Flit present on each input port |
| in_flit | input | NP*FW | Input flits; each has a 4-bit destination bank on top and a W-bit payload below |
| in_credit | output | NP | Credit returned upstream: one slot freed in that input buffer |
| out_valid | output | NP | Flit present on each output port |
| out_flit | output | NP*FW | Output flits, same layout as the inputs |
| credit_in | input | NP | Credit returned by the downstream buffer of each output |

## Verification
A central node receives flits for its own bank, for each of its three leaves and for banks in all three other groups. This separates the local, child and uplink decisions. The same sweep checks that nothing appears one cycle before the expected latency. A root instance and a leaf instance get destinations spread over every group, which exercises the group-index mapping and the local-versus-uplink choice. To show credit blocking, the bench withholds credits on one port while more flits than its credits are offered, and the stalled flit must wait until a single credit comes back. Three inputs are loaded so that they all contend for the uplink, and the order of the six grants shows whether the round-robin pointer moves on or stays stuck on the lowest input.

// File: rtl/tree_route_node.sv
`timescale 1ns/1ps
module tree_route_node #(
  parameter int KIND  = 1,
  parameter int ID    = 5,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int NP    = (KIND == 1) ? 5 : ((KIND == 2) ? 4 : 2),
  parameter int FW    = W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*FW-1:0] in_flit,
  output logic [NP-1:0]    in_credit,
  output logic [NP-1:0]    out_valid,
  output logic [NP*FW-1:0] out_flit,
  input  logic [NP-1:0]    credit_in
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [3:0] IDB = 4'(ID);
  localparam logic [1:0] QI  = {IDB[3], IDB[1]};
  localparam logic [1:0] SC  = ~QI;

  function automatic int route(input logic [3:0] d);
    logic [1:0] qd;
    logic [1:0] sd;
    qd = {d[3], d[1]};
    sd = {d[2], d[0]};
    if (KIND == 0)      return (d == IDB) ? 0 : 1;
    else if (KIND == 2) return int'(qd);
    else if (qd != QI)  return 4;
    else if (d == IDB)  return 0;
    else                return 1 + int'(sd) - ((sd > SC) ? 1 : 0);
  endfunction

  logic [FW-1:0] mem  [NP][DEPTH];
  logic [AW-1:0] wp   [NP];
  logic [AW-1:0] rp   [NP];
  logic [CW-1:0] occ  [NP];
  logic [CW-1:0] cred [NP];
  logic [PW-1:0] rr   [NP];
  logic [FW-1:0] head [NP];
  logic [PW-1:0] want [NP];
  logic [NP-1:0] gnt  [NP];
  logic [NP-1:0] hv;
  logic [NP-1:0] pop;

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign head[i] = mem[i][rp[i]];
    assign hv[i]   = occ[i] != '0;
    assign want[i] = PW'(route(head[i][FW-1 -: 4]));

    always_ff @(posedge clk) begin
      if (rst) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        occ[i] <= '0;
      end else begin
        if (in_valid[i]) begin
          mem[i][wp[i]] <= in_flit[i*FW +: FW];
          wp[i] <= (wp[i] == AW'(DEPTH - 1)) ? '0 : wp[i] + 1'b1;
        end
        if (pop[i])
          rp[i] <= (rp[i] == AW'(DEPTH - 1)) ? '0 : rp[i] + 1'b1;
        occ[i] <= occ[i] + CW'(in_valid[i]) - CW'(pop[i]);
      end
    end
  end

  always_comb begin
    int idx;
    for (int o = 0; o < NP; o++) begin
      gnt[o] = '0;
      for (int k = 0; k < NP; k++) begin
        idx = (int'(rr[o]) + k) % NP;
        if (gnt[o] == '0 && hv[idx] && int'(want[idx]) == o && cred[o] != '0)
          gnt[o][idx] = 1'b1;
      end
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NP; o++) pop = pop | gnt[o];
  end

  always_ff @(posedge clk) begin
    if (rst) in_credit <= '0;
    else     in_credit <= pop;
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [FW-1:0] pick;
    logic [FW-1:0] s2f;
    logic [FW-1:0] of;
    logic          s2v;
    logic          ov;
    int            win;

    always_comb begin
      pick = '0;
      win  = 0;
      for (int i = 0; i < NP; i++)
        if (gnt[o][i]) begin
          pick = head[i];
          win  = i;
        end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cred[o] <= CW'(DEPTH);
        rr[o]   <= '0;
        s2v     <= 1'b0;
        ov      <= 1'b0;
        s2f     <= '0;
        of      <= '0;
      end else begin
        cred[o] <= cred[o] - CW'(|gnt[o]) + CW'(credit_in[o]);
        if (|gnt[o]) rr[o] <= PW'((win + 1) % NP);
        s2v <= |gnt[o];
        s2f <= pick;
        ov  <= s2v;
        of  <= s2f;
      end
    end

    assign out_valid[o]           = ov;
    assign out_flit[o*FW +: FW]   = of;
  end
endmodule

// File: rtl/tree_route_node_chk.sv
`timescale 1ns/1ps
module tree_route_node_chk #(
  parameter int KIND  = 1,
  parameter int ID    = 5,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int NP    = 5,
  parameter int FW    = W + 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    in_valid,
  input logic [NP-1:0]    in_credit,
  input logic [NP-1:0]    out_valid,
  input logic [NP*FW-1:0] out_flit,
  input logic [NP-1:0]    credit_in
);
  localparam int CW = $clog2(DEPTH + 1) + 2;
  localparam logic [3:0] IDB = 4'(ID);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_credit == '0));

  for (genvar o = 0; o < NP; o++) begin : g_o
    logic [CW-1:0] outstanding;
    logic [3:0]    dst;
    assign dst = out_flit[o*FW+FW-1 -: 4];
    always_ff @(posedge clk) begin
      if (rst) outstanding <= '0;
      else     outstanding <= outstanding + CW'(out_valid[o]) - CW'(credit_in[o]);
    end
    assert_credit_bound_R7: assert property (@(posedge clk) disable iff (rst)
      outstanding <= CW'(DEPTH));

    if (KIND != 2 && o == 0) begin : g_loc
      assert_local_dest_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> dst == IDB);
    end
    if (KIND == 0 && o == 1) begin : g_leafup
      assert_leaf_up_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> dst != IDB);
    end
    if (KIND == 1 && o == 4) begin : g_cup
      assert_central_up_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> {dst[3], dst[1]} != {IDB[3], IDB[1]});
    end
    if (KIND == 2) begin : g_root
      assert_root_port_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> {dst[3], dst[1]} == 2'(o));
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_i
    logic [CW-1:0] held;
    always_ff @(posedge clk) begin
      if (rst) held <= '0;
      else     held <= held + CW'(in_valid[i]) - CW'(in_credit[i]);
    end
    assert_credit_return_R9: assert property (@(posedge clk) disable iff (rst)
      in_credit[i] |-> held != '0);
  end
endmodule

bind tree_route_node tree_route_node_chk #(
  .KIND(KIND), .ID(ID), .W(W), .DEPTH(DEPTH), .NP(NP), .FW(FW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_credit(in_credit),
  .out_valid(out_valid), .out_flit(out_flit), .credit_in(credit_in)
);

// File: tb/tree_route_node_tb.sv
`timescale 1ns/1ps
module tree_route_node_tb;
  localparam int CLK_NS = 10;
  localparam int FW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_NS/2) clk = ~clk;

  logic [4:0]    c_iv = '0, c_ic, c_ov, c_cr, c_cauto = '0, c_man = '0, c_auto = '1;
  logic [5*FW-1:0] c_if = '0, c_of;
  logic [3:0]    r_iv = '0, r_ic, r_ov;
  logic [4*FW-1:0] r_if = '0, r_of;
  logic [1:0]    l_iv = '0, l_ic, l_ov;
  logic [2*FW-1:0] l_if = '0, l_of;

  assign c_cr = c_cauto | c_man;
  always @(negedge clk) c_cauto <= c_ov & c_auto;

  tree_route_node #(.KIND(1), .ID(5)) u_dut (
    .clk(clk), .rst(rst), .in_valid(c_iv), .in_flit(c_if), .in_credit(c_ic),
    .out_valid(c_ov), .out_flit(c_of), .credit_in(c_cr));
  tree_route_node #(.KIND(2), .ID(0)) u_root (
    .clk(clk), .rst(rst), .in_valid(r_iv), .in_flit(r_if), .in_credit(r_ic),
    .out_valid(r_ov), .out_flit(r_of), .credit_in(4'b0000));
  tree_route_node #(.KIND(0), .ID(0)) u_leaf (
    .clk(clk), .rst(rst), .in_valid(l_iv), .in_flit(l_if), .in_credit(l_ic),
    .out_valid(l_ov), .out_flit(l_of), .credit_in(2'b00));

  int ncmp = 0, nfail = 0;
  int cnt [5];
  int nseq [5];
  logic [7:0] seq [5][8];

  always @(negedge clk)
    for (int p = 0; p < 5; p++)
      if (c_ov[p]) begin
        cnt[p]++;
        if (nseq[p] < 8) seq[p][nseq[p]] = c_of[p*FW +: 8];
        nseq[p]++;
      end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int p = 0; p < 5; p++) begin cnt[p] = 0; nseq[p] = 0; end
  endtask

  task automatic do_reset();
    rst = 1'b1; c_iv = '0; r_iv = '0; l_iv = '0; c_man = '0; c_auto = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_mon();
  endtask

  task automatic csend(input int p, input logic [3:0] d, input logic [7:0] pay);
    c_iv[p] = 1'b1; c_if[p*FW +: FW] = {d, pay};
    @(negedge clk);
    c_iv = '0;
  endtask

  function automatic int c_exp(input int d);
    case (d) 5: return 0; 0: return 1; 1: return 2; 4: return 3; default: return 4; endcase
  endfunction

  function automatic int r_exp(input int d);
    case (d)
      0, 1, 4, 5:    return 0;
      2, 3, 6, 7:    return 1;
      8, 9, 12, 13:  return 2;
      default:       return 3;
    endcase
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(c_ov == 0 && c_ic == 0, "R11 central idle in reset", int'(c_ov), 0);
    chk(r_ov == 0 && l_ov == 0, "R11 root/leaf idle in reset", int'(r_ov), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(c_ov == 0 && c_ic == 0, "R11 idle after release", int'(c_ic), 0);
    clear_mon();
  endtask

  task automatic t_central_route();
    int ds [8] = '{5, 0, 1, 4, 2, 9, 15, 12};
    string tag;
    do_reset();
    foreach (ds[n]) begin
      tag = (c_exp(ds[n]) == 0) ? "R1" : (c_exp(ds[n]) == 4) ? "R4" : "R3";
      csend(0, 4'(ds[n]), 8'(n + 16));
      @(negedge clk); #1;
      chk(c_ov == 0, "R6 early output", int'(c_ov), 0);
      @(negedge clk); #1;
      chk(c_ov == 5'(1 << c_exp(ds[n])), tag, int'(c_ov), 1 << c_exp(ds[n]));
      chk(c_of[c_exp(ds[n])*FW +: FW] == {4'(ds[n]), 8'(n + 16)}, tag,
          int'(c_of[c_exp(ds[n])*FW +: FW]), int'({4'(ds[n]), 8'(n + 16)}));
    end
  endtask

  task automatic t_root();
    int ds [6] = '{0, 7, 12, 15, 6, 10};
    do_reset();
    foreach (ds[n]) begin
      r_iv[n % 4] = 1'b1; r_if[(n % 4)*FW +: FW] = {4'(ds[n]), 8'(n)};
      @(negedge clk); r_iv = '0;
      repeat (2) @(negedge clk); #1;
      chk(r_ov == 4'(1 << r_exp(ds[n])), "R5 root port", int'(r_ov), 1 << r_exp(ds[n]));
    end
  endtask

  task automatic t_leaf();
    int ds [3] = '{0, 9, 3};
    do_reset();
    foreach (ds[n]) begin
      l_iv[0] = 1'b1; l_if[0 +: FW] = {4'(ds[n]), 8'(n)};
      @(negedge clk); l_iv = '0;
      repeat (2) @(negedge clk); #1;
      if (ds[n] == 0) chk(l_ov == 2'b01, "R1 leaf local", int'(l_ov), 1);
      else            chk(l_ov == 2'b10, "R2 leaf uplink", int'(l_ov), 2);
    end
  endtask

  task automatic t_credit();
    do_reset();
    c_auto = 5'b11101;
    for (int n = 0; n < 5; n++) csend(0, 4'd0, 8'(n));
    repeat (8) @(negedge clk); #1;
    chk(cnt[1] == 4, "R7 stall at zero credit", cnt[1], 4);
    c_man[1] = 1'b1;
    @(negedge clk);
    c_man = '0;
    repeat (6) @(negedge clk); #1;
    chk(cnt[1] == 5, "R7 resume after credit", cnt[1], 5);
    chk(seq[1][4] == 8'd4, "R7 stalled flit", int'(seq[1][4]), 4);
  endtask

  task automatic t_rr();
    logic [7:0] ex [6] = '{8'h01, 8'h02, 8'h03, 8'h11, 8'h12, 8'h13};
    do_reset();
    for (int r = 0; r < 2; r++) begin
      for (int p = 1; p <= 3; p++) begin
        c_iv[p] = 1'b1; c_if[p*FW +: FW] = {4'd10, 8'(r*16 + p)};
      end
      @(negedge clk);
      c_iv = '0;
    end
    repeat (10) @(negedge clk); #1;
    chk(nseq[4] == 6, "R8 grant count", nseq[4], 6);
    for (int n = 0; n < 6; n++)
      chk(seq[4][n] == ex[n], "R8 round-robin order", int'(seq[4][n]), int'(ex[n]));
  endtask

  task automatic t_fifo();
    do_reset();
    for (int n = 0; n < 3; n++) csend(2, 4'd4, 8'hA1 + 8'(n));
    repeat (6) @(negedge clk); #1;
    for (int n = 0; n < 3; n++)
      chk(seq[3][n] == 8'hA1 + 8'(n), "R10 arrival order", int'(seq[3][n]), 'hA1 + n);
  endtask

  task automatic t_incredit();
    do_reset();
    csend(2, 4'd10, 8'h55);
    #1 chk(c_ic == 0, "R9 no early credit", int'(c_ic), 0);
    @(negedge clk); #1;
    chk(c_ic == 5'b00100, "R9 credit pulse", int'(c_ic), 4);
    @(negedge clk); #1;
    chk(c_ic == 0, "R9 single pulse", int'(c_ic), 0);
  endtask

  initial begin
    #(CLK_NS * 50000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin
    clear_mon();
    t_reset();
    t_central_route();
    t_root();
    t_leaf();
    t_credit();
    t_rr();
    t_fifo();
    t_incredit();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule